// File: doc/BRIEF.md
# BCD Alarm Match Unit

This block keeps a calendar alarm made of five BCD fields (month, day of month, hour, minute, second). It compares them with the running BCD time-of-day that an external timekeeping counter supplies. When the counter's one-second tick arrives while all five fields agree, the unit sets a sticky alarm flag. An active-low interrupt output is driven low while that flag and the alarm enable bit are both set.

Software reaches the alarm bytes and the flags register through a byte-wide register port made of an address, write data, a write strobe and combinational read data. The month alarm byte also holds two control bits. One is the alarm interrupt enable. The other is a square-wave enable, which the unit only stores and presents on an output for a neighbouring divider. The flag stays set until software writes the flags register with the flag bit at zero. A clear that lands in the same cycle as a fresh match does not discard that match.

Top module: `alarm_match_unit`

## Requirements
- R1: The five alarm bytes sit at consecutive addresses 0 to 4 in the order month, day, hour, minute, second, and each reads back what was last written, subject to R2 and R3.
- R2: In the month alarm byte, bit 7 is the alarm interrupt enable and bit 6 is the square-wave enable. Bit 6 drives output `sqwEnable` from the cycle after the write. Bits 5:0 hold the BCD month.
- R3: The minute and second bytes keep bits 6:0. The day and hour bytes keep bits 5:0. Bits outside these fields are dropped on write and read as 0.
- R4: After reset every register reads 0x00, `alarmIrqN` is 1 and `sqwEnable` is 0.
- R5: When `secTick` is high at a clock edge and all five stored fields equal the masked time inputs, the alarm flag (flags register at address 5, bit 6) reads 1 from the next cycle.
- R6: The flag is not set by a full match without `secTick`, nor by `secTick` while any single field differs.
- R7: Once set, the flag stays at 1. It goes to 0 only after a write to address 5 with bit 6 at 0. A write with bit 6 at 1 leaves it unchanged.
- R8: `alarmIrqN` is 0 exactly while the alarm flag and the enable bit (month byte bit 7) are both 1, and is 1 otherwise.
- R9: A flag-clearing write in the same cycle as a tick with a full match leaves the flag set.
- R10: Bits of the flags register other than bit 6 read 0. Addresses 6 and 7 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe, one byte per cycle |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| timeMon | input | 6 | Current BCD month |
| timeDay | input | 6 | Current BCD day of month |
| timeHour | input | 6 | Current BCD hour |
| timeMin | input | 7 | Current BCD minute |
| timeSec | input | 7 | Current BCD second |
| secTick | input | 1 | One-cycle pulse marking each new second |
| alarmIrqN | output | 1 | Alarm interrupt, active low |
| sqwEnable | output | 1 | Stored square-wave enable bit |

## Verification
The bound checker tests the cycle-level rules on every clock. These rules are: a tick with a full match sets the flag on the next cycle; nothing but a tick can raise the flag; the flag holds unless a clearing write arrives; a clear that meets a match loses; the interrupt pin follows flag and enable; and the square-wave enable follows month-byte writes. The address map, the per-field bit masks, the reads of unmapped addresses, and the fact that a single mismatching field blocks the alarm can only be shown by the bench's directed scenarios, which read values back through the register port.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

  localparam int FIELD_CNT = 5;   // month, day, hour, minute, second
  localparam int FIELD_W   = 7;   // widest BCD field
  localparam int DATA_W    = 8;
  localparam int FLAG_BIT  = 6;   // alarm flag position in flags byte
  localparam int EN_BIT    = 7;   // interrupt enable in month byte
  localparam int SQW_BIT   = 6;   // square-wave enable in month byte

  // field index order equals address order
  localparam int IDX_MON  = 0;
  localparam int IDX_DAY  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_MIN  = 3;
  localparam int IDX_SEC  = 4;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_FIELD = 2'd1,
    RD_FLAGS = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic [FIELD_CNT-1:0] wrField;
    logic                 wrFlags;
    rdSel_t               rdSel;
    logic [2:0]           rdIdx;
  } ctrlStrobe_t;

  function automatic logic [FIELD_W-1:0] fieldMask(input int idx);
    if (idx == IDX_MIN || idx == IDX_SEC) return 7'h7F;
    return 7'h3F;
  endfunction

endpackage

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int ALARM_BASE = 0,
  parameter int FLAG_ADDR  = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);

  localparam int ALARM_LAST = ALARM_BASE + FIELD_CNT - 1;

  logic [FIELD_CNT-1:0] fieldSel;

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_sel
    assign fieldSel[i] = (regAddr == ADDR_W'(ALARM_BASE + i));
  end

  logic flagSel;
  assign flagSel = (regAddr == ADDR_W'(FLAG_ADDR));

  always_comb begin
    strobe         = '0;
    strobe.wrField = fieldSel & {FIELD_CNT{regWrEn}};
    strobe.wrFlags = flagSel & regWrEn;
    strobe.rdSel   = RD_NONE;
    strobe.rdIdx   = '0;
    if (int'(regAddr) >= ALARM_BASE && int'(regAddr) <= ALARM_LAST) begin
      strobe.rdSel = RD_FIELD;
      strobe.rdIdx = 3'(int'(regAddr) - ALARM_BASE);
    end else if (flagSel) begin
      strobe.rdSel = RD_FLAGS;
    end
  end

endmodule

// File: rtl/alarm_match_datapath.sv
module alarm_match_datapath
  import alarm_match_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strobe,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [FIELD_CNT-1:0][FIELD_W-1:0] timeField,
  input  logic                              secTick,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              flagQ,
  output logic                              alarmEnQ,
  output logic                              sqwEnQ,
  output logic                              matchEvent
);

  logic [FIELD_CNT-1:0][FIELD_W-1:0] fieldQ;
  logic [FIELD_CNT-1:0]              fieldHit;

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_field
    localparam logic [FIELD_W-1:0] MASK = fieldMask(i);

    always_ff @(posedge clk) begin
      if (!rstN)               fieldQ[i] <= '0;
      else if (strobe.wrField[i]) fieldQ[i] <= wrData[FIELD_W-1:0] & MASK;
    end

    assign fieldHit[i] = (fieldQ[i] == (timeField[i] & MASK));
  end

  // control bits that share the month byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmEnQ <= 1'b0;
      sqwEnQ   <= 1'b0;
    end else if (strobe.wrField[IDX_MON]) begin
      alarmEnQ <= wrData[EN_BIT];
      sqwEnQ   <= wrData[SQW_BIT];
    end
  end

  assign matchEvent = secTick & (&fieldHit);

  // a new match outranks a clearing write
  logic clearReq;
  assign clearReq = strobe.wrFlags & ~wrData[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN)           flagQ <= 1'b0;
    else if (matchEvent) flagQ <= 1'b1;
    else if (clearReq)   flagQ <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_FIELD: begin
        rdData[FIELD_W-1:0] = fieldQ[strobe.rdIdx];
        if (strobe.rdIdx == 3'(IDX_MON)) begin
          rdData[EN_BIT]  = alarmEnQ;
          rdData[SQW_BIT] = sqwEnQ;
        end
      end
      RD_FLAGS: rdData[FLAG_BIT] = flagQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int ALARM_BASE = 0,
  parameter int FLAG_ADDR  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              regWrEn,
  output logic [7:0]        regRdData,
  input  logic [5:0]        timeMon,
  input  logic [5:0]        timeDay,
  input  logic [5:0]        timeHour,
  input  logic [6:0]        timeMin,
  input  logic [6:0]        timeSec,
  input  logic              secTick,
  output logic              alarmIrqN,
  output logic              sqwEnable
);

  ctrlStrobe_t                       strobe;
  logic [FIELD_CNT-1:0][FIELD_W-1:0] timeField;
  logic                              flagQ;
  logic                              alarmEnQ;
  logic                              matchEvent;

  assign timeField[IDX_MON]  = {1'b0, timeMon};
  assign timeField[IDX_DAY]  = {1'b0, timeDay};
  assign timeField[IDX_HOUR] = {1'b0, timeHour};
  assign timeField[IDX_MIN]  = timeMin;
  assign timeField[IDX_SEC]  = timeSec;

  alarm_match_ctrl #(
    .ADDR_W    (ADDR_W),
    .ALARM_BASE(ALARM_BASE),
    .FLAG_ADDR (FLAG_ADDR)
  ) ctrl_i (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  alarm_match_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .timeField (timeField),
    .secTick   (secTick),
    .rdData    (regRdData),
    .flagQ     (flagQ),
    .alarmEnQ  (alarmEnQ),
    .sqwEnQ    (sqwEnable),
    .matchEvent(matchEvent)
  );

  assign alarmIrqN = ~(flagQ & alarmEnQ);

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int ADDR_W     = 3,
  parameter int ALARM_BASE = 0,
  parameter int FLAG_ADDR  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              regWrEn,
  input logic              secTick,
  input logic              alarmIrqN,
  input logic              sqwEnable,
  input logic              flagQ,
  input logic              alarmEnQ,
  input logic              matchEvent
);

  logic clearWr;
  logic monthWr;
  assign clearWr = regWrEn && (regAddr == ADDR_W'(FLAG_ADDR)) && !regWrData[6];
  assign monthWr = regWrEn && (regAddr == ADDR_W'(ALARM_BASE));

  // R5: tick with full match sets the flag next cycle
  a_r5_match_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    matchEvent |=> flagQ);

  // R6: the flag only rises on a tick
  a_r6_no_set_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !secTick) |=> !flagQ);

  // R7: flag holds unless a clearing write arrives
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clearWr) |=> flagQ);

  // R9: a clear that meets a match loses
  a_r9_match_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && matchEvent) |=> flagQ);

  // R8: interrupt pin follows flag and enable
  a_r8_irq_low_when_pending: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && alarmEnQ) |-> !alarmIrqN);

  a_r8_irq_high_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(flagQ && alarmEnQ) |-> alarmIrqN);

  // R2: square-wave enable follows month-byte bit 6
  a_r2_sqw_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    monthWr |=> (sqwEnable == $past(regWrData[6])));

endmodule

bind alarm_match_unit alarm_match_chk #(
  .ADDR_W    (ADDR_W),
  .ALARM_BASE(ALARM_BASE),
  .FLAG_ADDR (FLAG_ADDR)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regWrEn   (regWrEn),
  .secTick   (secTick),
  .alarmIrqN (alarmIrqN),
  .sqwEnable (sqwEnable),
  .flagQ     (flagQ),
  .alarmEnQ  (alarmEnQ),
  .matchEvent(matchEvent)
);

// File: tb/alarm_match_unit_tb.sv
`timescale 1ns/100ps
module alarm_match_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic [5:0] timeMon = '0, timeDay = '0, timeHour = '0;
  logic [6:0] timeMin = '0, timeSec = '0;
  logic       secTick = 1'b0;
  logic       alarmIrqN;
  logic       sqwEnable;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  alarm_match_unit dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .timeMon(timeMon),
    .timeDay(timeDay), .timeHour(timeHour), .timeMin(timeMin),
    .timeSec(timeSec), .secTick(secTick), .alarmIrqN(alarmIrqN),
    .sqwEnable(sqwEnable)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setTime(input logic [5:0] mo, input logic [5:0] dy,
                         input logic [5:0] hr, input logic [6:0] mi, input logic [6:0] se);
    timeMon = mo; timeDay = dy; timeHour = hr; timeMin = mi; timeSec = se;
  endtask

  task automatic pulseTick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      check("R4 reset register", v, 8'h00);
    end
    check("R4 reset irq", {7'd0, alarmIrqN}, 8'h01);
    check("R4 reset sqw", {7'd0, sqwEnable}, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] v;
    writeReg(3'd0, 8'h52);   // sqw on, enable off, month 0x12
    check("R2 sqw enable out", {7'd0, sqwEnable}, 8'h01);
    writeReg(3'd1, 8'hE5);   // day masked to 0x25
    writeReg(3'd2, 8'hD3);   // hour masked to 0x13
    writeReg(3'd3, 8'hC5);   // minute masked to 0x45
    writeReg(3'd4, 8'hB0);   // second masked to 0x30
    readReg(3'd0, v); check("R1 R2 month byte", v, 8'h52);
    readReg(3'd1, v); check("R3 day mask", v, 8'h25);
    readReg(3'd2, v); check("R3 hour mask", v, 8'h13);
    readReg(3'd3, v); check("R3 minute mask", v, 8'h45);
    readReg(3'd4, v); check("R3 second mask", v, 8'h30);
    writeReg(3'd0, 8'h12);
    check("R2 sqw enable cleared", {7'd0, sqwEnable}, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] v;
    setTime(6'h12, 6'h25, 6'h13, 7'h45, 7'h30);
    repeat (3) @(negedge clk);
    readReg(3'd5, v); check("R6 match without tick", v, 8'h00);
    setTime(6'h12, 6'h25, 6'h13, 7'h46, 7'h30);
    pulseTick();
    readReg(3'd5, v); check("R6 minute mismatch", v, 8'h00);
    setTime(6'h11, 6'h25, 6'h13, 7'h45, 7'h30);
    pulseTick();
    readReg(3'd5, v); check("R6 month mismatch", v, 8'h00);
    setTime(6'h12, 6'h25, 6'h13, 7'h45, 7'h30);
    pulseTick();
    readReg(3'd5, v); check("R5 flag set", v, 8'h40);
    check("R8 irq high while disabled", {7'd0, alarmIrqN}, 8'h01);
    writeReg(3'd0, 8'h92);
    check("R8 irq low when enabled", {7'd0, alarmIrqN}, 8'h00);
    setTime(6'h12, 6'h25, 6'h13, 7'h45, 7'h31);
    writeReg(3'd5, 8'hFF);
    repeat (4) @(negedge clk);
    readReg(3'd5, v); check("R7 write one keeps flag", v, 8'h40);
    writeReg(3'd5, 8'hBF);
    readReg(3'd5, v); check("R7 clear flag", v, 8'h00);
    check("R8 irq released", {7'd0, alarmIrqN}, 8'h01);
  endtask

  task automatic t_race();
    logic [7:0] v;
    setTime(6'h12, 6'h25, 6'h13, 7'h45, 7'h30);
    pulseTick();
    readReg(3'd5, v); check("R5 flag set again", v, 8'h40);
    @(negedge clk);
    regAddr = 3'd5; regWrData = 8'h00; regWrEn = 1'b1; secTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; secTick = 1'b0;
    readReg(3'd5, v); check("R9 clear loses to match", v, 8'h40);
    check("R9 irq stays low", {7'd0, alarmIrqN}, 8'h00);
    writeReg(3'd5, 8'h00);
    readReg(3'd5, v); check("R7 clear after race", v, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    writeReg(3'd6, 8'hFF);
    writeReg(3'd7, 8'hFF);
    readReg(3'd6, v); check("R10 addr 6 reads zero", v, 8'h00);
    readReg(3'd7, v); check("R10 addr 7 reads zero", v, 8'h00);
    readReg(3'd0, v); check("R10 month untouched", v, 8'h92);
    readReg(3'd4, v); check("R10 second untouched", v, 8'h30);
    readReg(3'd5, v); check("R10 flags untouched", v, 8'h00);
    check("R10 irq untouched", {7'd0, alarmIrqN}, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_map();
    t_match();
    t_race();
    t_unmapped();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!doneFlag) begin
      doneFlag = 1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule